// File: doc/BRIEF.md
# Floating-Point Control and Status Register Unit

This block holds the floating-point state of an integer core: a 3-bit dynamic rounding mode and five sticky exception flags. The integer side reaches this state through a CSR port. One stored state is reachable at three addresses. One address shows the whole register, one shows only the rounding mode and one shows only the flags. The rounding-mode and flags views are zero-extended to the data width. Every view accepts a read, a write or an atomic swap. A swap returns the old contents in the same cycle and loads the new value at the clock edge.

Completing floating-point operations OR their exception bits into the flags through an accumulate port. A CSR write and an accumulate can land in the same cycle, and no exception is lost when they do. A purely combinational resolver turns an instruction's 3-bit rounding field into the effective rounding mode. It takes a static code directly, or takes the stored dynamic mode when the field selects it. It flags reserved encodings, and the set of reserved codes differs between the static and dynamic cases. The block raises no trap.

Top module: `fpcsr_unit`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge) the rounding mode is 000 and all flags are 0, so a read of the full register at address 0x003 returns 0.
- R2: The full register at address 0x003 reads as {24 zero bits, rounding mode in bits 7:5, flags in bits 4:0}. A write there loads bits 7:0 and ignores bits 31:8, which always read as zero.
- R3: The rounding-mode view at address 0x002 reads the mode zero-extended in bits 2:0. A write there takes only `csr_wdata[2:0]` and leaves the flags unchanged.
- R4: The flags view at address 0x001 reads the flags zero-extended in bits 4:0. A write there takes only `csr_wdata[4:0]` and leaves the rounding mode unchanged. The flag order is invalid=bit 4, divide-by-zero=bit 3, overflow=bit 2, underflow=bit 1, inexact=bit 0.
- R5: A swap (`csr_op`=10) drives the view's prior contents on `csr_rdata` in its own cycle, and the new value is readable from the next cycle.
- R6: A read (`csr_op`=00) changes no state. A write (`csr_op`=01) drives `csr_rdata` to zero. Op 11 neither reads nor writes.
- R7: When `acc_valid` is high, `acc_flags` is ORed into the flags at the clock edge. A set flag stays set until a CSR write clears it. `acc_flags` has no effect while `acc_valid` is low.
- R8: When a CSR write and an accumulate hit the same edge, the flags become the written flags ORed with `acc_flags`.
- R9: An access to any address other than 0x001, 0x002 or 0x003 changes no state and returns zero on `csr_rdata`.
- R10: An instruction rounding field of 000 to 100 appears unchanged on `eff_rm`, with `rm_reserved` low.
- R11: An instruction rounding field of 101 or 110 drives `rm_reserved` high.
- R12: An instruction rounding field of 111 drives `eff_rm` from the stored mode. `rm_reserved` is high exactly when that stored mode is 101, 110 or 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csr_en | input | 1 | CSR access valid this cycle |
| csr_op | input | 2 | 00 read, 01 write, 10 swap, 11 none |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (combinational, prior contents) |
| acc_valid | input | 1 | Exception flags from a completing operation are valid |
| acc_flags | input | 5 | Exception flags to accumulate |
| ins_rm | input | 3 | Rounding field of the current instruction |
| eff_rm | output | 3 | Effective rounding mode |
| rm_reserved | output | 1 | Effective rounding encoding is reserved |

## Verification
A flag register that drops a bit shows up on the very next read of address 0x001 or 0x003 as a missing one, and it is checked after each accumulate. A wrong stored mode appears in the same cycle on `eff_rm` whenever `ins_rm` is 111. A bad mode also makes `rm_reserved` wrong for codes 101 to 111. A view that writes the wrong slice of the data shows up within one cycle when the full register is read back. The directed sequences chain their values, so a corrupted state propagates into every later expected value.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'b00,
      OP_WRITE = 2'b01,
      OP_SWAP  = 2'b10,
      OP_NONE  = 2'b11
   } csr_op_e;

   typedef enum logic [1:0] {
      VIEW_NONE  = 2'b00,
      VIEW_FLAGS = 2'b01,
      VIEW_MODE  = 2'b10,
      VIEW_FULL  = 2'b11
   } csr_view_e;
endpackage

// File: rtl/fpcsr_decode.sv
module fpcsr_decode
   import fpcsr_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int A_FLAGS  = 1,
   parameter int A_MODE   = 2,
   parameter int A_FULL   = 3
) (
   input  logic              en,
   input  logic [1:0]        op,
   input  logic [ADDR_W-1:0] addr,
   output csr_view_e         view,
   output logic              rd_en,
   output logic              wr_mode,
   output logic              wr_flags
);
   csr_op_e op_e;
   logic    wants_wr;

   assign op_e = csr_op_e'(op);

   always_comb begin
      view = VIEW_NONE;
      if (en) begin
         if (addr == ADDR_W'(A_FLAGS))     view = VIEW_FLAGS;
         else if (addr == ADDR_W'(A_MODE)) view = VIEW_MODE;
         else if (addr == ADDR_W'(A_FULL)) view = VIEW_FULL;
      end
   end

   assign wants_wr = (op_e == OP_WRITE) || (op_e == OP_SWAP);
   assign rd_en    = (view != VIEW_NONE) && ((op_e == OP_READ) || (op_e == OP_SWAP));
   assign wr_mode  = wants_wr && ((view == VIEW_MODE)  || (view == VIEW_FULL));
   assign wr_flags = wants_wr && ((view == VIEW_FLAGS) || (view == VIEW_FULL));
endmodule

// File: rtl/fpcsr_state.sv
module fpcsr_state #(
   parameter int          RM_W     = 3,
   parameter int          FLAG_W   = 5,
   parameter logic [2:0]  RM_RESET = 3'b000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_mode,
   input  logic [RM_W-1:0]   mode_wval,
   input  logic              wr_flags,
   input  logic [FLAG_W-1:0] flags_wval,
   input  logic              acc_valid,
   input  logic [FLAG_W-1:0] acc_flags,
   output logic [RM_W-1:0]   mode_q,
   output logic [FLAG_W-1:0] flags_q
);
   logic [FLAG_W-1:0] flags_d;

   generate
      for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
         logic base;
         assign base       = wr_flags ? flags_wval[i] : flags_q[i];
         assign flags_d[i] = base | (acc_valid & acc_flags[i]);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q  <= RM_W'(RM_RESET);
         flags_q <= '0;
      end else begin
         if (wr_mode) mode_q <= mode_wval;
         flags_q <= flags_d;
      end
   end

   assert_mode_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !wr_mode |=> $stable(mode_q));

   assert_flags_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      !wr_flags |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

   assert_acc_kept_R8: assert property (@(posedge clk) disable iff (rst)
      acc_valid |=> ((flags_q & $past(acc_flags)) == $past(acc_flags)));
endmodule

// File: rtl/fpcsr_readmux.sv
module fpcsr_readmux
   import fpcsr_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int RM_W   = 3,
   parameter int FLAG_W = 5
) (
   input  csr_view_e         view,
   input  logic              rd_en,
   input  logic [RM_W-1:0]   mode_q,
   input  logic [FLAG_W-1:0] flags_q,
   output logic [XLEN-1:0]   rdata
);
   always_comb begin
      rdata = '0;
      if (rd_en) begin
         unique case (view)
            VIEW_FLAGS: rdata[FLAG_W-1:0]         = flags_q;
            VIEW_MODE:  rdata[RM_W-1:0]           = mode_q;
            VIEW_FULL:  rdata[RM_W+FLAG_W-1:0]    = {mode_q, flags_q};
            default:    rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/fpcsr_rm_resolve.sv
module fpcsr_rm_resolve #(
   parameter int RM_W      = 3,
   parameter int MAX_LEGAL = 4
) (
   input  logic [RM_W-1:0] ins_rm,
   input  logic [RM_W-1:0] dyn_rm,
   output logic [RM_W-1:0] eff_rm,
   output logic            reserved
);
   localparam logic [RM_W-1:0] DYN_SEL = '1;
   localparam logic [RM_W-1:0] LIMIT   = RM_W'(MAX_LEGAL);

   logic use_dyn;

   assign use_dyn  = (ins_rm == DYN_SEL);
   assign eff_rm   = use_dyn ? dyn_rm : ins_rm;
   assign reserved = eff_rm > LIMIT;
endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
   import fpcsr_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int ADDR_W    = 12,
   parameter int RM_W      = 3,
   parameter int FLAG_W    = 5,
   parameter int A_FLAGS   = 1,
   parameter int A_MODE    = 2,
   parameter int A_FULL    = 3,
   parameter int MAX_LEGAL = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              csr_en,
   input  logic [1:0]        csr_op,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic [XLEN-1:0]   csr_wdata,
   output logic [XLEN-1:0]   csr_rdata,
   input  logic              acc_valid,
   input  logic [FLAG_W-1:0] acc_flags,
   input  logic [RM_W-1:0]   ins_rm,
   output logic [RM_W-1:0]   eff_rm,
   output logic              rm_reserved
);
   localparam int MODE_LSB = FLAG_W;
   localparam int USED_W   = RM_W + FLAG_W;

   generate
      if (XLEN < USED_W) begin : g_bad_xlen
         $error("fpcsr_unit: XLEN too small for mode and flags");
      end
      if (MAX_LEGAL >= (1 << RM_W) - 1) begin : g_bad_limit
         $error("fpcsr_unit: MAX_LEGAL collides with dynamic selector");
      end
   endgenerate

   csr_view_e         view;
   logic              rd_en, wr_mode, wr_flags;
   logic [RM_W-1:0]   mode_q, mode_wval;
   logic [FLAG_W-1:0] flags_q, flags_wval;

   fpcsr_decode #(
      .ADDR_W(ADDR_W), .A_FLAGS(A_FLAGS), .A_MODE(A_MODE), .A_FULL(A_FULL)
   ) u_decode (
      .en(csr_en), .op(csr_op), .addr(csr_addr),
      .view(view), .rd_en(rd_en), .wr_mode(wr_mode), .wr_flags(wr_flags)
   );

   assign mode_wval  = (view == VIEW_FULL) ? csr_wdata[MODE_LSB +: RM_W] : csr_wdata[RM_W-1:0];
   assign flags_wval = csr_wdata[FLAG_W-1:0];

   fpcsr_state #(.RM_W(RM_W), .FLAG_W(FLAG_W)) u_state (
      .clk(clk), .rst(rst),
      .wr_mode(wr_mode), .mode_wval(mode_wval),
      .wr_flags(wr_flags), .flags_wval(flags_wval),
      .acc_valid(acc_valid), .acc_flags(acc_flags),
      .mode_q(mode_q), .flags_q(flags_q)
   );

   fpcsr_readmux #(.XLEN(XLEN), .RM_W(RM_W), .FLAG_W(FLAG_W)) u_readmux (
      .view(view), .rd_en(rd_en), .mode_q(mode_q), .flags_q(flags_q),
      .rdata(csr_rdata)
   );

   fpcsr_rm_resolve #(.RM_W(RM_W), .MAX_LEGAL(MAX_LEGAL)) u_resolve (
      .ins_rm(ins_rm), .dyn_rm(mode_q), .eff_rm(eff_rm), .reserved(rm_reserved)
   );

   logic addr_hit;
   assign addr_hit = (csr_addr == ADDR_W'(A_FLAGS)) || (csr_addr == ADDR_W'(A_MODE)) ||
                     (csr_addr == ADDR_W'(A_FULL));

   assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
      (csr_en && !addr_hit) |-> (csr_rdata == '0));

   assert_unmapped_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      (csr_en && !addr_hit && !acc_valid) |=> ($stable(mode_q) && $stable(flags_q)));

   assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
      csr_rdata[XLEN-1:USED_W] == '0);

   assert_static_reserved_R11: assert property (@(posedge clk) disable iff (rst)
      ((ins_rm != '1) && (ins_rm > RM_W'(MAX_LEGAL))) |-> rm_reserved);

   assert_dyn_follow_R12: assert property (@(posedge clk) disable iff (rst)
      (ins_rm == '1) |-> (eff_rm == mode_q));
endmodule

// File: tb/tb_fpcsr_unit.sv
module tb_fpcsr_unit;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        csr_en = 1'b0;
   logic [1:0]  csr_op = 2'b11;
   logic [11:0] csr_addr = '0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        acc_valid = 1'b0;
   logic [4:0]  acc_flags = '0;
   logic [2:0]  ins_rm = '0;
   logic [2:0]  eff_rm;
   logic        rm_reserved;

   int n_chk = 0;
   int n_bad = 0;

   localparam logic [1:0] RD = 2'b00, WR = 2'b01, SW = 2'b10;
   localparam logic [11:0] AF = 12'h001, AM = 12'h002, AX = 12'h003;

   always #5 clk = ~clk;

   fpcsr_unit dut (
      .clk(clk), .rst(rst), .csr_en(csr_en), .csr_op(csr_op), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .acc_valid(acc_valid),
      .acc_flags(acc_flags), .ins_rm(ins_rm), .eff_rm(eff_rm), .rm_reserved(rm_reserved)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One CSR cycle, optionally with an accumulate; rdata captured before the edge.
   task automatic access(input logic [1:0] op, input logic [11:0] a, input logic [31:0] d,
                         input logic av, input logic [4:0] af, output logic [31:0] rd);
      @(negedge clk);
      csr_en = 1'b1; csr_op = op; csr_addr = a; csr_wdata = d;
      acc_valid = av; acc_flags = af;
      #1 rd = csr_rdata;
      @(negedge clk);
      csr_en = 1'b0; csr_op = 2'b11; acc_valid = 1'b0; acc_flags = '0;
   endtask

   task automatic rd_full(output logic [31:0] rd);
      access(RD, AX, 32'h0, 1'b0, 5'h0, rd);
   endtask

   task automatic t_reset;
      logic [31:0] r;
      rd_full(r);
      check("R1 full after reset", r, 32'h0);
      access(RD, AM, 32'h0, 1'b0, 5'h0, r);
      check("R1 mode after reset", r, 32'h0);
   endtask

   task automatic t_full;
      logic [31:0] r;
      access(WR, AX, 32'hFFFF_FFFF, 1'b0, 5'h0, r);
      check("R6 write rdata zero", r, 32'h0);
      rd_full(r);
      check("R2 upper ignored", r, 32'h0000_00FF);
      access(WR, AX, 32'h1234_56A5, 1'b0, 5'h0, r);
      rd_full(r);
      check("R2 full load", r, 32'h0000_00A5);
   endtask

   task automatic t_mode_view;
      logic [31:0] r;
      access(WR, AM, 32'hFFFF_FFFB, 1'b0, 5'h0, r);
      access(RD, AM, 32'h0, 1'b0, 5'h0, r);
      check("R3 mode view read", r, 32'h3);
      rd_full(r);
      check("R3 flags untouched", r, 32'h65);
   endtask

   task automatic t_flags_view;
      logic [31:0] r;
      access(WR, AF, 32'hFFFF_FFF2, 1'b0, 5'h0, r);
      access(RD, AF, 32'h0, 1'b0, 5'h0, r);
      check("R4 flags view read", r, 32'h12);
      rd_full(r);
      check("R4 mode untouched", r, 32'h72);
   endtask

   task automatic t_swap;
      logic [31:0] r;
      access(SW, AX, 32'h0000_0041, 1'b0, 5'h0, r);
      check("R5 swap full old", r, 32'h72);
      rd_full(r);
      check("R5 swap full new", r, 32'h41);
      access(SW, AM, 32'h6, 1'b0, 5'h0, r);
      check("R5 swap mode old", r, 32'h2);
      rd_full(r);
      check("R5 swap mode new", r, 32'hC1);
      access(SW, AF, 32'h1E, 1'b0, 5'h0, r);
      check("R5 swap flags old", r, 32'h1);
      rd_full(r);
      check("R5 swap flags new", r, 32'hDE);
   endtask

   task automatic t_read_op;
      logic [31:0] r;
      access(RD, AX, 32'hFFFF_FF00, 1'b0, 5'h0, r);
      access(2'b11, AX, 32'h0000_0000, 1'b0, 5'h0, r);
      check("R6 op11 rdata zero", r, 32'h0);
      rd_full(r);
      check("R6 read/none no change", r, 32'hDE);
   endtask

   task automatic t_sticky;
      logic [31:0] r;
      access(WR, AF, 32'h0, 1'b0, 5'h0, r);
      access(RD, AF, 32'h0, 1'b1, 5'h10, r);
      access(RD, AF, 32'h0, 1'b0, 5'h0, r);
      check("R7 invalid flag set", r, 32'h10);
      access(RD, AF, 32'h0, 1'b1, 5'h01, r);
      access(RD, AF, 32'h0, 1'b1, 5'h00, r);
      check("R7 sticky accumulate", r, 32'h11);
      access(RD, AM, 32'h0, 1'b0, 5'h0E, r);
      access(RD, AF, 32'h0, 1'b0, 5'h0, r);
      check("R7 acc ignored when invalid", r, 32'h11);
   endtask

   task automatic t_collide;
      logic [31:0] r;
      access(WR, AF, 32'h04, 1'b1, 5'h01, r);
      access(RD, AF, 32'h0, 1'b0, 5'h0, r);
      check("R8 flag write plus acc", r, 32'h05);
      access(WR, AM, 32'h1, 1'b1, 5'h08, r);
      rd_full(r);
      check("R8 mode write plus acc", r, 32'h2D);
      access(WR, AX, 32'h0, 1'b1, 5'h02, r);
      rd_full(r);
      check("R8 full write plus acc", r, 32'h02);
   endtask

   task automatic t_unmapped;
      logic [31:0] r;
      access(WR, AX, 32'hA3, 1'b0, 5'h0, r);
      access(SW, 12'h004, 32'hFF, 1'b0, 5'h0, r);
      check("R9 unmapped rdata", r, 32'h0);
      access(WR, 12'h000, 32'hFF, 1'b0, 5'h0, r);
      access(RD, 12'h803, 32'h0, 1'b0, 5'h0, r);
      check("R9 unmapped read", r, 32'h0);
      rd_full(r);
      check("R9 state unchanged", r, 32'hA3);
   endtask

   task automatic t_resolve;
      logic [31:0] r;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); ins_rm = 3'(i); #1;
         check("R10 static eff", {29'h0, eff_rm}, i);
         check("R10 static legal", {31'h0, rm_reserved}, 32'h0);
      end
      for (int i = 5; i < 7; i++) begin
         @(negedge clk); ins_rm = 3'(i); #1;
         check("R11 static reserved", {31'h0, rm_reserved}, 32'h1);
      end
      for (int m = 0; m < 8; m++) begin
         access(WR, AM, 32'(m), 1'b0, 5'h0, r);
         ins_rm = 3'b111; #1;
         check("R12 dynamic eff", {29'h0, eff_rm}, m);
         check("R12 dynamic reserved", {31'h0, rm_reserved}, (m > 4) ? 32'h1 : 32'h0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_full();
      t_mode_view();
      t_flags_view();
      t_swap();
      t_read_op();
      t_sticky();
      t_collide();
      t_unmapped();
      t_resolve();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule